// File: doc/BRIEF.md
# Flash Portal Command Engine

This block lets a local controller reach an attached flash array without driving the serial flash protocol itself. Software writes a flash address, a local buffer address and a command word into registers. It then writes a go bit. The engine checks the command and places one request on a valid/ready flash request port. For a read, it stores each returned byte into the local buffer. For a write, it streams bytes out of the buffer. For an erase, it only waits. When the flash side signals completion, the engine records done and any failure in a status register. Status bits are cleared by writing one to them.

The flash port is an abstract request/response interface. After a request is accepted, read data arrives one byte per `fl_rd_valid` beat. Write data leaves one byte per `fl_wr_valid`/`fl_wr_ready` handshake. A single-cycle `fl_done` pulse, qualified by `fl_err`, closes the transaction. The local buffer is reached through a byte-wide port whose read data is combinational from `buf_addr`.

The state machine has five states:
- `ST_IDLE`: waits for a go pulse. A go with a bad command stays here and posts done plus an error bit.
- `ST_ISSUE`: holds the request until `fl_req_ready`.
- `ST_READ`: collects read beats.
- `ST_WRITE`: sends write beats.
- `ST_WAIT`: waits for `fl_done`.

The transitions are:
- `ST_IDLE` goes to `ST_ISSUE` on an accepted go.
- `ST_ISSUE` goes to `ST_READ`, `ST_WRITE` or `ST_WAIT` on ready, chosen by the command type.
- `ST_READ` and `ST_WRITE` go to `ST_WAIT` after the last beat.
- `ST_WAIT` goes to `ST_IDLE` on `fl_done`.

Register word indices on `reg_addr`:
- 0: flash address.
- 1: buffer address.
- 2: command.
- 3: go (bit 0, write only).
- 4: interrupt enable (bit 0).
- 5: status.

Top module: `flash_portal_engine`

## Requirements
- R1: For read and write commands, the length field is a byte count, and only 1 to 64 is accepted. Any other value sets status bit 1 together with done (bit 0), and no flash request is raised.
- R2: The command word holds the type in bits [1:0] (0 read, 1 write, 2 erase) and the length in bits [14:8], and reads back as written. Type 3 sets status bit 3 and done without a flash request.
- R3: For erase, the length field is a size code. Code 0 (4 KB) is always accepted. Code 1 (32 KB) needs `erase_cap[0]`, and code 2 (64 KB) needs `erase_cap[1]`. Any other code, or a code whose capability bit is clear, sets status bit 2 and done without a request.
- R4: An accepted read raises a request with op 0, the programmed flash address and the byte count. The n-th read beat is written to buffer address (buffer address + n) mod 256.
- R5: An accepted write raises a request with op 1. It then presents byte n from buffer address (buffer address + n) mod 256 on the n-th write handshake, for exactly the byte count.
- R6: An accepted erase raises a request with op 2 and the size code, and produces no data beats.
- R7: Busy (status bit 8) reads 1 from the first edge after an accepted go until the edge where done is set. A go, or a command-register write, while busy has no effect on the running transfer and starts nothing new.
- R8: A go while the `enable` input is low is ignored: status stays zero and no request is raised.
- R9: `fl_done` in the wait state sets done on that edge. If `fl_err` is high, it also sets status bit 4. The error mask is status bits [4:1].
- R10: Writing status clears exactly the bits written as 1. Bits written as 0 keep their value.
- R11: `irq` equals done AND interrupt-enable bit 0.
- R12: While a request is waiting for ready, its op, address and length stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Overall flash-access enable; a go is ignored while low |
| erase_cap | input | NSIZES-1 (2) | Bit i allows erase size code i+1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Done interrupt |
| fl_req_valid | output | 1 | Flash request valid |
| fl_req_ready | input | 1 | Flash request accepted |
| fl_req_op | output | 2 | Request type |
| fl_req_addr | output | FAW (24) | Flash byte address |
| fl_req_len | output | LENW (7) | Byte count or erase size code |
| fl_rd_valid | input | 1 | Read data beat |
| fl_rd_data | input | 8 | Read data byte |
| fl_wr_valid | output | 1 | Write data beat offered |
| fl_wr_ready | input | 1 | Write data beat taken |
| fl_wr_data | output | 8 | Write data byte |
| fl_done | input | 1 | Transaction complete pulse |
| fl_err | input | 1 | Failure flag qualifying fl_done |
| buf_addr | output | BAW (8) | Local buffer byte address |
| buf_we | output | 1 | Local buffer write strobe |
| buf_wdata | output | 8 | Local buffer write byte |
| buf_rdata | input | 8 | Local buffer read byte for buf_addr |

## Verification
A rejected go posts its done and error bits on the edge that samples the go, so the bench reads status at the falling edge right after that write. An accepted go shows busy and `fl_req_valid` at that same falling edge. Read data is written to the buffer on the edge of each beat, and the bench compares the buffer after the last beat. Done, flash error and `irq` appear on the edge that samples `fl_done`, so the bench drives the flash model and reads the registers only on falling edges, one full cycle before any result is expected.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_READ,
        ST_WRITE,
        ST_WAIT
    } state_e;

    // error group, packed so it lands on status bits [4:1]
    typedef struct packed {
        logic flash;
        logic cmd;
        logic erase;
        logic len;
    } err_t;

    localparam int REG_FADDR  = 0;
    localparam int REG_BADDR  = 1;
    localparam int REG_CMD    = 2;
    localparam int REG_GO     = 3;
    localparam int REG_IRQEN  = 4;
    localparam int REG_STATUS = 5;

    localparam int SB_DONE    = 0;
    localparam int SB_ERR_LSB = 1;
    localparam int SB_BUSY    = 8;

    localparam int CMD_LEN_LSB = 8;

endpackage

// File: rtl/fpe_check.sv
module fpe_check
    import fpe_pkg::*;
#(
    parameter int MAXLEN = 64,
    parameter int NSIZES = 3,
    parameter int LENW   = 7
) (
    input  op_e              op_i,
    input  logic [LENW-1:0]  len_i,
    input  logic [NSIZES-2:0] cap_i,
    output logic             ok_o,
    output err_t             err_o
);

    logic size_ok;

    always_comb begin
        size_ok = (len_i == '0);
        for (int i = 1; i < NSIZES; i++) begin
            if (len_i == LENW'(i) && cap_i[i-1]) begin
                size_ok = 1'b1;
            end
        end
    end

    always_comb begin
        err_o = '0;
        unique case (op_i)
            OP_READ, OP_WRITE: err_o.len   = (len_i == '0) || (len_i > LENW'(MAXLEN));
            OP_ERASE:          err_o.erase = !size_ok;
            OP_RSVD:           err_o.cmd   = 1'b1;
        endcase
        ok_o = !(err_o.len || err_o.erase || err_o.cmd);
    end

endmodule

// File: rtl/fpe_regs.sv
module fpe_regs
    import fpe_pkg::*;
#(
    parameter int FAW  = 24,
    parameter int BAW  = 8,
    parameter int LENW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            busy_i,
    input  logic            set_done_i,
    input  err_t            set_err_i,
    output logic [FAW-1:0]  faddr_o,
    output logic [BAW-1:0]  baddr_o,
    output op_e             op_o,
    output logic [LENW-1:0] len_o,
    output logic            start_o,
    output logic            irq_en_o,
    output logic            done_o
);

    logic [1:0] op_q;
    err_t       err_q;
    logic       done_q;
    logic       wr_st;
    logic [4:0] clr_bits;
    logic       unused_bits;

    assign unused_bits = ^reg_wdata;
    assign wr_st    = reg_we && (reg_addr == 3'(REG_STATUS));
    assign clr_bits = wr_st ? reg_wdata[4:0] : 5'd0;
    assign start_o  = reg_we && (reg_addr == 3'(REG_GO)) && reg_wdata[0];
    assign op_o     = op_e'(op_q);
    assign done_o   = done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            faddr_o  <= '0;
            baddr_o  <= '0;
            op_q     <= '0;
            len_o    <= '0;
            irq_en_o <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr)
                3'(REG_FADDR): faddr_o  <= reg_wdata[FAW-1:0];
                3'(REG_BADDR): baddr_o  <= reg_wdata[BAW-1:0];
                3'(REG_CMD): begin
                    op_q  <= reg_wdata[1:0];
                    len_o <= reg_wdata[CMD_LEN_LSB +: LENW];
                end
                3'(REG_IRQEN): irq_en_o <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // status: write-one-to-clear, hardware set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= '0;
        end else begin
            done_q <= (done_q && !clr_bits[SB_DONE]) || set_done_i;
            err_q  <= (err_q & ~err_t'(clr_bits[4:1])) | set_err_i;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            3'(REG_FADDR): reg_rdata[FAW-1:0] = faddr_o;
            3'(REG_BADDR): reg_rdata[BAW-1:0] = baddr_o;
            3'(REG_CMD): begin
                reg_rdata[1:0]                 = op_q;
                reg_rdata[CMD_LEN_LSB +: LENW] = len_o;
            end
            3'(REG_IRQEN): reg_rdata[0] = irq_en_o;
            3'(REG_STATUS): begin
                reg_rdata[SB_DONE]       = done_q;
                reg_rdata[SB_ERR_LSB +: 4] = err_q;
                reg_rdata[SB_BUSY]       = busy_i;
            end
            default: ;
        endcase
    end

    // R9
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(busy_i || start_o));

    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && reg_wdata[SB_DONE] && !set_done_i) |=> !done_q);

endmodule

// File: rtl/fpe_fsm.sv
module fpe_fsm
    import fpe_pkg::*;
#(
    parameter int FAW    = 24,
    parameter int BAW    = 8,
    parameter int LENW   = 7,
    parameter int MAXLEN = 64,
    parameter int NSIZES = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            enable_i,
    input  logic            chk_ok_i,
    input  err_t            chk_err_i,
    input  op_e             op_i,
    input  logic [LENW-1:0] len_i,
    input  logic [FAW-1:0]  faddr_i,
    input  logic [BAW-1:0]  baddr_i,
    output logic            fl_req_valid,
    input  logic            fl_req_ready,
    output op_e             fl_req_op,
    output logic [FAW-1:0]  fl_req_addr,
    output logic [LENW-1:0] fl_req_len,
    input  logic            fl_rd_valid,
    input  logic [7:0]      fl_rd_data,
    output logic            fl_wr_valid,
    input  logic            fl_wr_ready,
    output logic [7:0]      fl_wr_data,
    input  logic            fl_done,
    input  logic            fl_err,
    output logic [BAW-1:0]  buf_addr,
    output logic            buf_we,
    output logic [7:0]      buf_wdata,
    input  logic [7:0]      buf_rdata,
    output logic            busy_o,
    output logic            set_done_o,
    output err_t            set_err_o
);

    state_e          state_q, state_d;
    op_e             op_q;
    logic [LENW-1:0] len_q;
    logic [FAW-1:0]  faddr_q;
    logic [BAW-1:0]  baddr_q;
    logic [LENW-1:0] cnt_q;
    logic            accept;
    logic            last_beat;
    logic            beat;

    assign accept    = (state_q == ST_IDLE) && start_i && enable_i && chk_ok_i;
    assign last_beat = (cnt_q + LENW'(1)) == len_q;
    assign beat      = ((state_q == ST_READ) && fl_rd_valid) ||
                       ((state_q == ST_WRITE) && fl_wr_ready);
    assign busy_o    = (state_q != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_READ;
            len_q   <= '0;
            faddr_q <= '0;
            baddr_q <= '0;
            cnt_q   <= '0;
        end else if (accept) begin
            op_q    <= op_i;
            len_q   <= len_i;
            faddr_q <= faddr_i;
            baddr_q <= baddr_i;
            cnt_q   <= '0;
        end else if (beat) begin
            cnt_q   <= cnt_q + LENW'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: if (fl_req_ready) begin
                unique case (op_q)
                    OP_READ:  state_d = ST_READ;
                    OP_WRITE: state_d = ST_WRITE;
                    default:  state_d = ST_WAIT;
                endcase
            end
            ST_READ:  if (fl_rd_valid && last_beat) state_d = ST_WAIT;
            ST_WRITE: if (fl_wr_ready && last_beat) state_d = ST_WAIT;
            ST_WAIT:  if (fl_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        fl_req_valid = (state_q == ST_ISSUE);
        fl_req_op    = op_q;
        fl_req_addr  = faddr_q;
        fl_req_len   = len_q;
        fl_wr_valid  = 1'b0;
        fl_wr_data   = buf_rdata;
        buf_addr     = baddr_q + BAW'(cnt_q);
        buf_we       = 1'b0;
        buf_wdata    = fl_rd_data;
        set_done_o   = 1'b0;
        set_err_o    = '0;
        unique case (state_q)
            ST_IDLE: if (start_i && enable_i && !chk_ok_i) begin
                set_done_o = 1'b1;
                set_err_o  = chk_err_i;
            end
            ST_READ:  buf_we = fl_rd_valid;
            ST_WRITE: fl_wr_valid = 1'b1;
            ST_WAIT: if (fl_done) begin
                set_done_o      = 1'b1;
                set_err_o.flash = fl_err;
            end
            default: ;
        endcase
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_valid && !fl_req_ready) |=>
            (fl_req_valid && $stable(fl_req_addr) && $stable(fl_req_len) && $stable(fl_req_op)));

    // R1
    req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_valid && fl_req_op != OP_ERASE) |->
            (fl_req_len != '0 && fl_req_len <= LENW'(MAXLEN)));

    // R3
    erase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req_valid && fl_req_op == OP_ERASE) |-> (fl_req_len < LENW'(NSIZES)));

    // R2
    no_rsvd_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req_valid |-> (fl_req_op != OP_RSVD));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i && enable_i));

    // R6
    erase_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_q == OP_ERASE) |-> (!buf_we && !fl_wr_valid));

endmodule

// File: rtl/flash_portal_engine.sv
module flash_portal_engine
    import fpe_pkg::*;
#(
    parameter  int FAW    = 24,
    parameter  int BAW    = 8,
    parameter  int MAXLEN = 64,
    parameter  int NSIZES = 3,
    localparam int LENW   = $clog2(MAXLEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [NSIZES-2:0] erase_cap,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              fl_req_valid,
    input  logic              fl_req_ready,
    output logic [1:0]        fl_req_op,
    output logic [FAW-1:0]    fl_req_addr,
    output logic [LENW-1:0]   fl_req_len,
    input  logic              fl_rd_valid,
    input  logic [7:0]        fl_rd_data,
    output logic              fl_wr_valid,
    input  logic              fl_wr_ready,
    output logic [7:0]        fl_wr_data,
    input  logic              fl_done,
    input  logic              fl_err,
    output logic [BAW-1:0]    buf_addr,
    output logic              buf_we,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata
);

    logic            busy, set_done, start, irq_en, done, chk_ok;
    err_t            set_err, chk_err;
    op_e             cmd_op, req_op;
    logic [LENW-1:0] cmd_len;
    logic [FAW-1:0]  faddr;
    logic [BAW-1:0]  baddr;

    assign fl_req_op = req_op;
    assign irq       = done && irq_en;

    fpe_regs #(.FAW(FAW), .BAW(BAW), .LENW(LENW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy),
        .set_done_i (set_done),
        .set_err_i  (set_err),
        .faddr_o    (faddr),
        .baddr_o    (baddr),
        .op_o       (cmd_op),
        .len_o      (cmd_len),
        .start_o    (start),
        .irq_en_o   (irq_en),
        .done_o     (done)
    );

    fpe_check #(.MAXLEN(MAXLEN), .NSIZES(NSIZES), .LENW(LENW)) u_check (
        .op_i  (cmd_op),
        .len_i (cmd_len),
        .cap_i (erase_cap),
        .ok_o  (chk_ok),
        .err_o (chk_err)
    );

    fpe_fsm #(.FAW(FAW), .BAW(BAW), .LENW(LENW), .MAXLEN(MAXLEN), .NSIZES(NSIZES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .enable_i     (enable),
        .chk_ok_i     (chk_ok),
        .chk_err_i    (chk_err),
        .op_i         (cmd_op),
        .len_i        (cmd_len),
        .faddr_i      (faddr),
        .baddr_i      (baddr),
        .fl_req_valid (fl_req_valid),
        .fl_req_ready (fl_req_ready),
        .fl_req_op    (req_op),
        .fl_req_addr  (fl_req_addr),
        .fl_req_len   (fl_req_len),
        .fl_rd_valid  (fl_rd_valid),
        .fl_rd_data   (fl_rd_data),
        .fl_wr_valid  (fl_wr_valid),
        .fl_wr_ready  (fl_wr_ready),
        .fl_wr_data   (fl_wr_data),
        .fl_done      (fl_done),
        .fl_err       (fl_err),
        .buf_addr     (buf_addr),
        .buf_we       (buf_we),
        .buf_wdata    (buf_wdata),
        .buf_rdata    (buf_rdata),
        .busy_o       (busy),
        .set_done_o   (set_done),
        .set_err_o    (set_err)
    );

    // R11
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_done && busy && !fl_req_valid && !fl_wr_valid && irq_en && !reg_we) |=> irq);

endmodule

// File: tb/flash_portal_engine_tb.sv
module flash_portal_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [1:0]  erase_cap = 2'b00;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        fl_req_valid;
    logic        fl_req_ready = 1'b0;
    logic [1:0]  fl_req_op;
    logic [23:0] fl_req_addr;
    logic [6:0]  fl_req_len;
    logic        fl_rd_valid = 1'b0;
    logic [7:0]  fl_rd_data = 8'd0;
    logic        fl_wr_valid;
    logic        fl_wr_ready = 1'b0;
    logic [7:0]  fl_wr_data;
    logic        fl_done = 1'b0;
    logic        fl_err = 1'b0;
    logic [7:0]  buf_addr;
    logic        buf_we;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata;

    logic [7:0]  tbmem [256];
    int          nchk = 0;
    int          nerr = 0;
    bit          finished = 1'b0;
    bit          irq_en_tb = 1'b0;

    always #2 clk = ~clk;

    flash_portal_engine u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .erase_cap(erase_cap),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .fl_req_valid(fl_req_valid), .fl_req_ready(fl_req_ready),
        .fl_req_op(fl_req_op), .fl_req_addr(fl_req_addr), .fl_req_len(fl_req_len),
        .fl_rd_valid(fl_rd_valid), .fl_rd_data(fl_rd_data), .fl_wr_valid(fl_wr_valid),
        .fl_wr_ready(fl_wr_ready), .fl_wr_data(fl_wr_data), .fl_done(fl_done),
        .fl_err(fl_err), .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    // local buffer model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) tbmem[i] <= 8'(i * 13 + 7);
        end else if (buf_we) begin
            tbmem[buf_addr] <= buf_wdata;
        end
    end
    assign buf_rdata = tbmem[buf_addr];

    task automatic check(input bit cond, input string req, input int act, input int exp);
        nchk++;
        if (!cond) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input int d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input int a, output int d);
        reg_addr = 3'(a);
        #1;
        d = int'(reg_rdata);
    endtask

    function automatic bit exp_ok(input int op, input int len, input int cap);
        if (op <= 1) return (len >= 1 && len <= 64);
        if (op == 2) return (len == 0) || (len == 1 && cap[0]) || (len == 2 && cap[1]);
        return 1'b0;
    endfunction

    function automatic int exp_errbits(input int op);
        if (op <= 1) return 2;
        if (op == 2) return 4;
        return 8;
    endfunction

    function automatic logic [7:0] pat(input int fa, input int i);
        return 8'(fa * 3 + i * 5 + 1);
    endfunction

    task automatic run_cmd(input int op, input int len, input int fa, input int ba,
                           input int cap, input bit inj, input int rdly,
                           input bit poke, input bit keep);
        int st;
        int beats;
        int guard;
        string tag;
        tag = (op == 0) ? "R4" : (op == 1) ? "R5" : (op == 2) ? "R6" : "R2";
        erase_cap = 2'(cap);
        reg_write(0, fa);
        reg_write(1, ba);
        reg_write(2, (len << 8) | op);
        reg_write(3, 1);
        if (!exp_ok(op, len, cap)) begin
            reg_read(5, st);
            if (op <= 1)      check(st == 3, "R1 reject status", st, 3);
            else if (op == 2) check(st == 5, "R3 reject status", st, 5);
            else              check(st == 9, "R2 reject status", st, 9);
            check(fl_req_valid == 1'b0, "R1 no request on reject", int'(fl_req_valid), 0);
            reg_write(5, 'h1F);
            return;
        end
        reg_read(5, st);
        check(st == 'h100, "R7 busy after go", st, 'h100);
        check(fl_req_valid && fl_req_op == 2'(op) && fl_req_addr == 24'(fa) && fl_req_len == 7'(len),
              tag, {fl_req_valid, fl_req_op, fl_req_len}, {1'b1, 2'(op), 7'(len)});
        if (poke) begin
            reg_write(2, (3 << 8) | 1);
            reg_write(3, 1);
            check(fl_req_valid && fl_req_op == 2'(op) && fl_req_len == 7'(len),
                  "R7 go while busy ignored", int'(fl_req_len), len);
        end
        for (int k = 0; k < rdly; k++) begin
            check(fl_req_valid == 1'b1, "R12 request held", int'(fl_req_valid), 1);
            @(negedge clk);
        end
        check(fl_req_addr == 24'(fa) && fl_req_len == 7'(len), "R12 request stable",
              int'(fl_req_addr), fa);
        fl_req_ready = 1'b1;
        @(negedge clk);
        fl_req_ready = 1'b0;
        if (op == 0) begin
            for (int i = 0; i < len; i++) begin
                fl_rd_valid = 1'b1;
                fl_rd_data  = pat(fa, i);
                @(negedge clk);
            end
            fl_rd_valid = 1'b0;
            for (int i = 0; i < len; i++) begin
                check(tbmem[(ba + i) & 255] == pat(fa, i), "R4 buffer byte",
                      int'(tbmem[(ba + i) & 255]), int'(pat(fa, i)));
            end
        end else if (op == 1) begin
            beats = 0;
            guard = 0;
            while (beats < len && guard < 400) begin
                fl_wr_ready = guard[0];
                #0;
                if (fl_wr_valid && fl_wr_ready) begin
                    check(fl_wr_data == tbmem[(ba + beats) & 255], "R5 write byte",
                          int'(fl_wr_data), int'(tbmem[(ba + beats) & 255]));
                    beats++;
                end
                guard++;
                @(negedge clk);
            end
            fl_wr_ready = 1'b0;
            check(beats == len && !fl_wr_valid, "R5 write beat count", beats, len);
        end else begin
            check(!fl_wr_valid && !buf_we, "R6 erase has no data", int'(fl_wr_valid), 0);
        end
        fl_done = 1'b1;
        fl_err  = inj;
        @(negedge clk);
        fl_done = 1'b0;
        fl_err  = 1'b0;
        reg_read(5, st);
        check(st == (inj ? 'h11 : 'h01), "R9 completion status", st, inj ? 'h11 : 'h01);
        check(irq == irq_en_tb, "R11 irq", int'(irq), int'(irq_en_tb));
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(!fl_req_valid, "R7 no second request", int'(fl_req_valid), 0);
            end
        end
        if (!keep) reg_write(5, 'h1F);
    endtask

    initial begin
        int st;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(5, st);
        check(st == 0 && !irq && !fl_req_valid && !buf_we, "R9 reset state", st, 0);

        // command word field layout
        reg_write(2, (37 << 8) | 2);
        reg_read(2, st);
        check(st == ((37 << 8) | 2), "R2 command readback", st, (37 << 8) | 2);

        // read / write over every length code
        for (int op = 0; op < 2; op++)
            for (int len = 0; len < 128; len++)
                run_cmd(op, len, len * 16 + op, (len * 3) & 255, 0, 1'b0, len % 3, 1'b0, 1'b0);

        // erase over every size code and capability setting
        for (int cap = 0; cap < 4; cap++)
            for (int len = 0; len < 128; len++)
                run_cmd(2, len, 4096 * len, 0, cap, (len == 0 && cap == 3), 1, 1'b0, 1'b0);

        // reserved command type
        for (int len = 0; len < 128; len += 9)
            run_cmd(3, len, 0, 0, 3, 1'b0, 0, 1'b0, 1'b0);

        // go while busy and command rewrite while busy
        run_cmd(0, 8, 'h5000, 40, 0, 1'b0, 1, 1'b1, 1'b0);

        // enable low
        enable = 1'b0;
        reg_write(2, (4 << 8) | 0);
        reg_write(3, 1);
        for (int k = 0; k < 3; k++) begin
            reg_read(5, st);
            check(st == 0 && !fl_req_valid, "R8 go ignored when disabled", st, 0);
            @(negedge clk);
        end
        enable = 1'b1;

        // interrupt and write-one-to-clear
        reg_write(4, 1);
        irq_en_tb = 1'b1;
        run_cmd(2, 0, 'h2000, 0, 0, 1'b1, 0, 1'b0, 1'b1);
        reg_write(5, 0);
        reg_read(5, st);
        check(st == 'h11 && irq, "R10 zero write keeps bits", st, 'h11);
        reg_write(5, 1);
        reg_read(5, st);
        check(st == 'h10, "R10 clear done only", st, 'h10);
        check(!irq, "R11 irq drops with done", int'(irq), 0);
        reg_write(5, 'h10);
        reg_read(5, st);
        check(st == 0, "R10 clear flash error", st, 0);
        run_cmd(2, 0, 0, 0, 0, 1'b0, 0, 1'b0, 1'b1);
        reg_write(4, 0);
        irq_en_tb = 1'b0;
        #1;
        check(!irq, "R11 irq masked while done", int'(irq), 0);
        reg_write(5, 'h1F);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule